// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one character into a framed serial bit stream on a single output line. The frame shape is chosen while the block runs: character length (five to nine bits), parity kind, one or two stop bits, and whether bit timing comes from a bit-rate tick or from an external shift clock. All of these are held in an 8-bit control word plus one extra size bit. The control word is laid out as follows: bits [7:6] hold the timing mode, bits [5:4] the parity kind, bit [3] the stop count, bits [2:1] the two low bits of the size code, and bit [0] the shift-clock polarity. The high bit of the size code comes in on its own pin and is written together with the word.

A host writes the control word, then pulses the load strobe with a character. The block takes a snapshot of the format and the character, raises busy, and waits for the first timing event. It then drives a low start bit, the character least significant bit first, an optional parity bit and the high stop bits. Every bit moves on one timing event. In tick mode each `bit_tick_i` pulse is an event. In clocked mode the external shift clock is brought into the block clock domain, and its rising or falling edge is the event, depending on the polarity bit.

Top module: `sfx_tx`

## Requirements
- R1: After reset the line is high, busy is low, and the control word is 0x06 with the size bit at 0. A frame loaded without any control write is therefore tick-timed, has no parity, has one stop bit and carries 8 data bits: 10 bits in all.
- R2: A frame is sent as follows: a start bit at 0, then the character bits starting from bit 0, then the optional parity bit, then the stop bits at 1. In tick mode each bit appears in the cycle after a tick and is held until the next tick.
- R3: The 3-bit size code {size pin, word[2:1]} gives 5, 6, 7 or 8 bits for codes 000 to 011 and 9 bits for code 111. Codes 100, 101 and 110 give 8 bits. After the last stop bit, one more event drops busy.
- R4: Parity field word[5:4] works as follows. Values 00 and 01 send no parity bit. Value 10 sends the XOR of the character bits (even). Value 11 sends its inverse (odd).
- R5: Stop select word[3] at 0 sends one stop bit, and at 1 sends two.
- R6: Busy rises in the cycle after a load strobe that arrives while idle. Until the first event the line stays high. Busy falls only on the event that follows the last stop bit.
- R7: A load strobe while busy is ignored, and the frame in flight is unchanged.
- R8: The format is sampled at load. Control writes during a frame do not change that frame.
- R9: Mode word[7:6]=01 uses the shift clock. With word[0]=0 each rising edge advances one bit. With word[0]=1 each falling edge advances one bit. The other edge and bit ticks are ignored in this mode.
- R10: Mode values 00, 10 and 11 all use tick timing. In these modes the polarity bit and shift-clock edges have no effect.
- R11: Character bits above the selected length have no effect on the frame or on the parity bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and releases synchronously |
| cfg_we_i | input | 1 | Write strobe for the control word and the size bit |
| cfg_word_i | input | 8 | Control word: mode [7:6], parity [5:4], stop [3], size low [2:1], polarity [0] |
| cfg_size2_i | input | 1 | High bit of the size code |
| load_i | input | 1 | Start-frame strobe; accepted only while idle |
| data_i | input | 9 | Character to send; bits above the selected length are unused |
| bit_tick_i | input | 1 | One-cycle bit-rate pulse used in tick mode |
| sclk_i | input | 1 | External shift clock used in clocked mode |
| txd_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | High from load until the frame ends |

## Verification
The bench builds the block with its default parameters: a two-stage shift-clock synchronizer, a two-stage reset release and a reset word of 0x06. With these settings a clocked-mode event reaches the line a fixed three cycles after the edge, so the bench can sample at known points. Frames are short enough that every size code, including the three reserved ones, can be crossed with every parity value and both stop counts in tick mode, spread over all three tick-timed mode values. A set of clocked-mode frames covers both polarities. Some frames are hit mid-flight with a load strobe, a control write and stray edges or ticks on the unused timing source.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

  localparam int CHAR_MAX = 9;
  localparam int FRAME_W  = CHAR_MAX + 4;
  localparam int CNT_W    = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    MD_TICK  = 2'b00,
    MD_SCLK  = 2'b01,
    MD_RSVD  = 2'b10,
    MD_OTHER = 2'b11
  } mode_e;

  typedef struct packed {
    logic       use_sclk;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
    logic       pol;
    logic [3:0] nbits;
  } fmt_t;

  function automatic logic [3:0] char_len(input logic [2:0] code);
    logic [3:0] n;
    case (code)
      3'b000:  n = 4'd5;
      3'b001:  n = 4'd6;
      3'b010:  n = 4'd7;
      3'b111:  n = 4'd9;
      default: n = 4'd8;
    endcase
    return n;
  endfunction

  function automatic fmt_t decode_fmt(input logic [7:0] w, input logic size2);
    fmt_t  f;
    mode_e m;
    m          = mode_e'(w[7:6]);
    f.use_sclk = (m == MD_SCLK);
    f.par_en   = w[5];
    f.par_odd  = w[5] & w[4];
    f.two_stop = w[3];
    f.pol      = (m == MD_SCLK) & w[0];
    f.nbits    = char_len({size2, w[2:1]});
    return f;
  endfunction

endpackage

// File: rtl/sfx_rst_sync.sv
module sfx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign rst_n_o = sr_q[STAGES-1];

endmodule

// File: rtl/sfx_cfg_reg.sv
module sfx_cfg_reg #(
  parameter logic [7:0] RESET_WORD = 8'h06
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [7:0] word_i,
  input  logic       size2_i,
  output logic [7:0] word_o,
  output logic       size2_o
);

  logic [7:0] word_q, word_d;
  logic       size2_q, size2_d;

  always_comb begin
    word_d  = word_q;
    size2_d = size2_q;
    if (we_i) begin
      word_d  = word_i;
      size2_d = size2_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= RESET_WORD;
      size2_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      size2_q <= size2_d;
    end
  end

  assign word_o  = word_q;
  assign size2_o = size2_q;

endmodule

// File: rtl/sfx_step_gen.sv
module sfx_step_gen #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic tick_i,
  input  logic use_sclk_i,
  input  logic pol_i,
  output logic step_o
);

  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;
  logic            rise, fall;

  for (genvar g = 0; g <= STAGES; g++) begin : g_chain
    if (g == 0) begin : g_head
      assign chain_d[g] = sclk_i;
    end else begin : g_body
      assign chain_d[g] = chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  always_comb begin
    rise   = chain_q[STAGES-1] & ~chain_q[STAGES];
    fall   = ~chain_q[STAGES-1] & chain_q[STAGES];
    step_o = use_sclk_i ? (pol_i ? fall : rise) : tick_i;
  end

endmodule

// File: rtl/sfx_frame_build.sv
module sfx_frame_build
  import sfx_pkg::*;
(
  input  logic [CHAR_MAX-1:0] data_i,
  input  logic [3:0]          nbits_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                two_stop_i,
  output logic [FRAME_W-1:0]  frame_o,
  output logic [CNT_W-1:0]    len_o
);

  localparam int IDX_W = $clog2(FRAME_W);

  logic [CHAR_MAX-1:0] kept;
  logic                par_bit;
  logic [IDX_W-1:0]    par_idx;

  for (genvar g = 0; g < CHAR_MAX; g++) begin : g_keep
    assign kept[g] = data_i[g] & (nbits_i > 4'(g));
  end

  always_comb begin
    par_bit = (^kept) ^ par_odd_i;
    par_idx = IDX_W'(nbits_i) + IDX_W'(1);
    frame_o = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < CHAR_MAX; i++) begin
      if (nbits_i > 4'(i)) frame_o[i+1] = kept[i];
    end
    if (par_en_i) frame_o[par_idx] = par_bit;
    len_o = CNT_W'(nbits_i) + CNT_W'(2) + CNT_W'(par_en_i) + CNT_W'(two_stop_i);
  end

endmodule

// File: rtl/sfx_shifter.sv
module sfx_shifter
  import sfx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   len_i,
  input  logic               use_sclk_i,
  input  logic               pol_i,
  input  logic               step_i,
  output logic               busy_o,
  output logic               txd_o,
  output logic               use_sclk_o,
  output logic               pol_o
);

  logic               busy_q, busy_d;
  logic               txd_q, txd_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   len_q, len_d;
  logic               sclk_q, sclk_d;
  logic               pol_q, pol_d;

  always_comb begin
    busy_d = busy_q;
    txd_d  = txd_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    sclk_d = sclk_q;
    pol_d  = pol_q;
    if (!busy_q && load_i) begin
      busy_d = 1'b1;
      sh_d   = frame_i;
      len_d  = len_i;
      cnt_d  = '0;
      sclk_d = use_sclk_i;
      pol_d  = pol_i;
    end else if (busy_q && step_i) begin
      if (cnt_q == len_q) begin
        busy_d = 1'b0;
        txd_d  = 1'b1;
      end else begin
        txd_d = sh_q[0];
        sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      sh_q   <= '1;
      cnt_q  <= '0;
      len_q  <= '0;
      sclk_q <= 1'b0;
      pol_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      txd_q  <= txd_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      sclk_q <= sclk_d;
      pol_q  <= pol_d;
    end
  end

  assign busy_o     = busy_q;
  assign txd_o      = txd_q;
  assign use_sclk_o = sclk_q;
  assign pol_o      = pol_q;

endmodule

// File: rtl/sfx_tx.sv
module sfx_tx
  import sfx_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         RST_STAGES  = 2,
  parameter logic [7:0] CFG_RESET   = 8'h06
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we_i,
  input  logic [7:0]          cfg_word_i,
  input  logic                cfg_size2_i,
  input  logic                load_i,
  input  logic [CHAR_MAX-1:0] data_i,
  input  logic                bit_tick_i,
  input  logic                sclk_i,
  output logic                txd_o,
  output logic                busy_o
);

  logic               rst_sync_n;
  logic [7:0]         cfg_word_q;
  logic               cfg_size2_q;
  fmt_t               fmt;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   frame_len;
  logic               frame_sclk;
  logic               frame_pol;
  logic               step_evt;

  sfx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  sfx_cfg_reg #(.RESET_WORD(CFG_RESET)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (cfg_we_i),
    .word_i  (cfg_word_i),
    .size2_i (cfg_size2_i),
    .word_o  (cfg_word_q),
    .size2_o (cfg_size2_q)
  );

  assign fmt = decode_fmt(cfg_word_q, cfg_size2_q);

  sfx_frame_build u_build (
    .data_i     (data_i),
    .nbits_i    (fmt.nbits),
    .par_en_i   (fmt.par_en),
    .par_odd_i  (fmt.par_odd),
    .two_stop_i (fmt.two_stop),
    .frame_o    (frame),
    .len_o      (frame_len)
  );

  sfx_step_gen #(.STAGES(SYNC_STAGES)) u_step (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sclk_i     (sclk_i),
    .tick_i     (bit_tick_i),
    .use_sclk_i (frame_sclk),
    .pol_i      (frame_pol),
    .step_o     (step_evt)
  );

  sfx_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (load_i),
    .frame_i    (frame),
    .len_i      (frame_len),
    .use_sclk_i (fmt.use_sclk),
    .pol_i      (fmt.pol),
    .step_i     (step_evt),
    .busy_o     (busy_o),
    .txd_o      (txd_o),
    .use_sclk_o (frame_sclk),
    .pol_o      (frame_pol)
  );

endmodule

// File: rtl/sfx_tx_chk.sv
module sfx_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic load,
  input logic step,
  input logic busy,
  input logic txd
);

  // R1: the line rests high whenever no frame is in flight
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R2: the line moves only on a timing event
  a_r2_moves_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(txd));

  // R6: busy starts only from a load strobe
  a_r6_busy_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load));

  // R6: busy ends only on a timing event
  a_r6_busy_ends_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !step |=> busy);

  // R7: a load during a frame leaves line and busy untouched
  a_r7_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && load && !step |=> busy && $stable(txd));

endmodule

bind sfx_tx sfx_tx_chk u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .load  (load_i),
  .step  (step_evt),
  .busy  (busy_o),
  .txd   (txd_o)
);

// File: tb/sim_sfx_tx.sv
module sim_sfx_tx;
  import sfx_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                cfg_we = 1'b0;
  logic [7:0]          cfg_word = 8'h00;
  logic                cfg_size2 = 1'b0;
  logic                load = 1'b0;
  logic [CHAR_MAX-1:0] data = '0;
  logic                bit_tick = 1'b0;
  logic                sclk = 1'b0;
  logic                txd;
  logic                busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done_flag = 1'b0;

  sfx_tx u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_word_i  (cfg_word),
    .cfg_size2_i (cfg_size2),
    .load_i      (load),
    .data_i      (data),
    .bit_tick_i  (bit_tick),
    .sclk_i      (sclk),
    .txd_o       (txd),
    .busy_o      (busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R6 watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  // One timing event; returns at a falling edge after the design has reacted.
  task automatic do_step(input bit sy, input bit pol);
    if (!sy) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
    end else begin
      @(negedge clk) sclk = ~pol;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic sclk_idle(input bit pol);
    @(negedge clk) sclk = pol;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] w, input logic s2, input logic [8:0] d,
                           input bit write_cfg, input bit disturb, input string len_tag);
    bit         sy, pol, p;
    int         code, n, pos, len;
    logic       exp_bits [16];
    string      tags [16];
    sy   = (w[7:6] == 2'b01);
    pol  = sy & w[0];
    code = int'({s2, w[2:1]});
    n    = (code == 7) ? 9 : (code > 3) ? 8 : 5 + code;
    exp_bits[0] = 1'b0;
    tags[0]     = "R2";
    for (int i = 0; i < n; i++) begin
      exp_bits[1+i] = d[i];
      tags[1+i]     = "R2/R11";
    end
    pos = 1 + n;
    if (w[5]) begin
      p = 1'b0;
      for (int i = 0; i < n; i++) p ^= d[i];
      exp_bits[pos] = p ^ w[4];
      tags[pos]     = "R4";
      pos++;
    end
    exp_bits[pos] = 1'b1;
    tags[pos]     = "R5";
    pos++;
    if (w[3]) begin
      exp_bits[pos] = 1'b1;
      tags[pos]     = "R5";
      pos++;
    end
    len = pos;

    if (sy) sclk_idle(pol);
    if (write_cfg) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_word = w; cfg_size2 = s2;
      @(negedge clk) cfg_we = 1'b0;
    end
    repeat (3) @(negedge clk);
    @(negedge clk);
    load = 1'b1; data = d;
    @(negedge clk) load = 1'b0;
    check(busy === 1'b1, "R6 busy after load", int'(busy), 1);
    check(txd === 1'b1, "R6 line high before first event", int'(txd), 1);

    for (int i = 0; i < len; i++) begin
      if (disturb && i == 2) begin
        @(negedge clk);
        load = 1'b1; data = ~d;
        cfg_we = 1'b1; cfg_word = 8'h7E; cfg_size2 = ~s2;
        @(negedge clk);
        load = 1'b0; cfg_we = 1'b0;
        if (sy) begin
          @(negedge clk) bit_tick = 1'b1;
          @(negedge clk) bit_tick = 1'b0;
        end else begin
          for (int k = 0; k < 3; k++) begin
            @(negedge clk) sclk = ~sclk;
            repeat (3) @(negedge clk);
          end
        end
        repeat (2) @(negedge clk);
        check(txd === exp_bits[1], sy ? "R7/R9 held during disturbance" : "R7/R10 held during disturbance",
              int'(txd), int'(exp_bits[1]));
        check(busy === 1'b1, "R7 busy held", int'(busy), 1);
      end
      do_step(sy, pol);
      check(txd === exp_bits[i], tags[i], int'(txd), int'(exp_bits[i]));
      check(busy === 1'b1, "R6 busy within frame", int'(busy), 1);
      if (sy) begin
        sclk_idle(pol);
        check(txd === exp_bits[i], "R9 other edge ignored", int'(txd), int'(exp_bits[i]));
      end
    end
    do_step(sy, pol);
    check(busy === 1'b0, len_tag, int'(busy), 0);
    check(txd === 1'b1, "R1 line idle after frame", int'(txd), 1);
    if (sy) sclk_idle(pol);
    if (disturb) check(1'b1, "R8 frame kept its loaded format", 0, 0);
  endtask

  initial begin
    int it;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(txd === 1'b1, "R1 line high after reset", int'(txd), 1);
    check(busy === 1'b0, "R1 busy low after reset", int'(busy), 0);

    // R1: default word gives 8 data bits, no parity, one stop bit
    run_frame(8'h06, 1'b0, 9'h0B5, 1'b0, 1'b0, "R1 default frame length");

    // R3 R4 R5 R10: every size, parity and stop setting in all tick modes
    it = 0;
    for (int code = 0; code < 8; code++) begin
      for (int par = 0; par < 4; par++) begin
        for (int st = 0; st < 2; st++) begin
          logic [1:0] m;
          logic [7:0] w;
          m = (it % 3 == 0) ? 2'b00 : (it % 3 == 1) ? 2'b10 : 2'b11;
          w = {m, 2'(par), 1'(st), 2'(code), 1'b0};
          run_frame(w, 1'(code >> 2), 9'(it * 73 + 341), 1'b1, (it % 5) == 0, "R3 frame length");
          it++;
        end
      end
    end

    // R9: clocked mode, both polarities
    for (int pl = 0; pl < 2; pl++) begin
      for (int k = 0; k < 4; k++) begin
        int code;
        logic [7:0] w;
        code = (k == 0) ? 0 : (k == 1) ? 3 : (k == 2) ? 7 : 5;
        w = {2'b01, 1'b1, 1'(k & 1), 1'(k >> 1), 2'(code), 1'(pl)};
        run_frame(w, 1'(code >> 2), 9'(k * 151 + pl * 29 + 77), 1'b1, k == 1, "R9 clocked frame length");
      end
    end

    finish_run();
  end

endmodule